// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block takes a CPU physical address of 36 bits and decides which of up to four SDRAM ranks, if any, it falls into. Each rank has two 32-bit configuration words, a base word and a size word, held in a small register bank. The bank is written and read through a simple word-wide register port. Windows are 16 MB granular: only address bits 35:24 take part in the match.

For a matching address the block reports a hit, the index of the rank, and an attribute byte. Other bus masters must present this byte to reach that rank. The low nibble of the byte is active-low one-hot on the rank index. Bit 4 is a coherency flag, taken from a configuration input.

The block also reports how many enabled ranks lie entirely in the first 4 GB, which are the ones a 32-bit master can reach. A constant DRAM target identifier of zero is provided alongside. The lookup and the count are registered, so they follow their inputs by one clock.

Top module: `dram_cs_decoder`

## Requirements
- R1: After a synchronous active-high reset, every rank is disabled, and hit_o, cs_idx_o, attr_o, low_cs_cnt_o and rd_data_o are all zero.
- R2: reg_addr_i is a byte offset. Rank n's base word sits at n*8 and its size word at n*8+4. rd_data_o returns the word at reg_addr_i one clock later. Only these bits are stored; all others read as zero: base bits 31:24 and 3:0, and size bits 31:24, 4:2 and 0.
- R3: Size word bit 0 enables the rank. A disabled rank never hits, whatever its base and size.
- R4: An address hits an enabled rank when two conditions hold. First, addr bits 31:24 ANDed with the inverse of size bits 31:24 equal base bits 31:24. Second, address bits 23:0 are ignored, because (size-1) has its low 24 bits set.
- R5: When several enabled ranks match, the lowest index is reported.
- R6: On a hit, attr_o bits 3:0 are 4'hF with bit cs_idx_o cleared. attr_o bit 4 equals coh_en_i, and bits 7:5 are zero. target_id_o is always 0.
- R7: On a miss, hit_o is 0, and both cs_idx_o and attr_o are 0.
- R8: Address bits 35:32 must equal base word bits 3:0 for a hit.
- R9: low_cs_cnt_o counts the ranks that are enabled and have base bits 3:0 all zero.
- R10: hit_o, cs_idx_o and attr_o reflect the addr_i and coh_en_i sampled at the previous clock edge. A register write takes effect in the lookup from the next edge. low_cs_cnt_o reflects register contents one edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Registered read data for reg_addr_i |
| coh_en_i | input | 1 | Hardware coherency enable, merged into attribute bit 4 |
| addr_i | input | 36 | Lookup address |
| hit_o | output | 1 | Address falls in an enabled rank |
| cs_idx_o | output | 2 | Index of matching rank |
| attr_o | output | 8 | Attribute byte for the matching rank |
| target_id_o | output | 4 | DRAM target identifier, constant zero |
| low_cs_cnt_o | output | 3 | Enabled ranks based below 4 GB |

## Verification
Every output of this block is due exactly one edge after the inputs it depends on. The lookup uses the address and coherency input sampled at that edge, together with the register contents before any write at the same edge. Read data and the rank count follow the same rule. The bench keeps a behavioural shadow of the register words. At each step it computes the expected values from the shadow before applying that step's write, then compares all outputs shortly after the next rising edge. Overlap, above-4 GB bases, disabled ranks with a matching base, and coherency toggles are each exercised on that one-edge schedule.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int ADDR_W = 36;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic       en;
    logic [2:0] csnum;
    logic [7:0] sz_hi;    // (size-1) bits 31:24
    logic [7:0] base_lo;  // base bits 31:24
    logic [3:0] base_hi;  // base bits 35:32
  } dcs_win_t;
endpackage

// File: rtl/dcs_regfile.sv
module dcs_regfile import dcs_pkg::*; #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int RA_W  = IDX_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rd_data,
  output dcs_win_t [NUM_CS-1:0]   win_o
);
  dcs_win_t [NUM_CS-1:0] win_q;
  logic [IDX_W-1:0] sel;
  assign sel = reg_addr[RA_W-1:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      rd_data <= '0;
    end else begin
      if (reg_addr[2])
        rd_data <= {win_q[sel].sz_hi, 19'd0, win_q[sel].csnum, 1'b0, win_q[sel].en};
      else
        rd_data <= {win_q[sel].base_lo, 20'd0, win_q[sel].base_hi};
      if (wr_en) begin
        if (reg_addr[2]) begin
          win_q[sel].sz_hi <= wdata[31:24];
          win_q[sel].csnum <= wdata[4:2];
          win_q[sel].en    <= wdata[0];
        end else begin
          win_q[sel].base_lo <= wdata[31:24];
          win_q[sel].base_hi <= wdata[3:0];
        end
      end
    end
  end

  assign win_o = win_q;

  // R3: a size write sets the rank's enable from write data bit 0
  p_enable_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr[2]) |=> (win_o[$past(sel)].en == $past(wdata[0])));
endmodule

// File: rtl/dcs_match.sv
module dcs_match import dcs_pkg::*; (
  input  dcs_win_t           win,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  always_comb begin
    hit = win.en
       && (addr[35:32] == win.base_hi)
       && ((addr[31:24] & ~win.sz_hi) == win.base_lo);
  end
endmodule

// File: rtl/dcs_select.sv
module dcs_select #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CS-1:0] hits,
  input  logic              coh_en,
  output logic              hit_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [7:0]        attr_q
);
  logic [IDX_W-1:0] idx_d;
  logic [7:0]       attr_d;
  logic             any;

  always_comb begin
    idx_d = '0;
    any   = |hits;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (hits[i]) idx_d = IDX_W'(i);
    attr_d = '0;
    if (any) begin
      attr_d[3:0]      = 4'hF;
      attr_d[idx_d]    = 1'b0;
      attr_d[4]        = coh_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      idx_q  <= '0;
      attr_q <= '0;
    end else begin
      hit_q  <= any;
      idx_q  <= idx_d;
      attr_q <= attr_d;
    end
  end

  // R6: exactly the selected rank's bit is low in the nibble
  p_attr_onecold_r6: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> (attr_q[idx_q] == 1'b0 && $countones(attr_q[3:0]) == 3 && attr_q[7:5] == 3'd0));
  // R6: coherency flag follows the sampled input
  p_coh_flag_r6: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> (attr_q[4] == $past(coh_en)));
  // R7: a miss returns zeros
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (attr_q == 8'd0 && idx_q == '0));
endmodule

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder import dcs_pkg::*; #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int RA_W  = IDX_W + 3,
  localparam int CNT_W = $clog2(NUM_CS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              coh_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  cs_idx_o,
  output logic [7:0]        attr_o,
  output logic [3:0]        target_id_o,
  output logic [CNT_W-1:0]  low_cs_cnt_o
);
  dcs_win_t [NUM_CS-1:0] win;
  logic [NUM_CS-1:0]     hits;
  logic [CNT_W-1:0]      cnt_d;

  dcs_regfile #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_i), .reg_addr(reg_addr_i),
    .wdata(reg_wdata_i), .rd_data(rd_data_o), .win_o(win)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    dcs_match u_m (.win(win[g]), .addr(addr_i), .hit(hits[g]));
  end

  dcs_select #(.NUM_CS(NUM_CS)) u_sel (
    .clk(clk), .rst(rst), .hits(hits), .coh_en(coh_en_i),
    .hit_q(hit_o), .idx_q(cs_idx_o), .attr_q(attr_o)
  );

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (win[i].en && win[i].base_hi == 4'd0) cnt_d = cnt_d + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) low_cs_cnt_o <= '0;
    else     low_cs_cnt_o <= cnt_d;
  end

  assign target_id_o = 4'd0;

  // R9: count never exceeds the number of ranks
  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    low_cs_cnt_o <= CNT_W'(NUM_CS));
endmodule

// File: tb/sim_dram_cs_decoder.sv
module sim_dram_cs_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0, rst = 1;
  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] rd_data;
  logic        coh_en = 0;
  logic [35:0] addr = 0;
  logic        hit;
  logic [1:0]  cs_idx;
  logic [7:0]  attr;
  logic [3:0]  target_id;
  logic [2:0]  cnt;

  dram_cs_decoder u0 (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .rd_data_o(rd_data), .coh_en_i(coh_en),
    .addr_i(addr), .hit_o(hit), .cs_idx_o(cs_idx), .attr_o(attr),
    .target_id_o(target_id), .low_cs_cnt_o(cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  string req = "R1";
  logic [31:0] m_base [4];
  logic [31:0] m_size [4];
  logic        e_hit;
  logic [1:0]  e_idx;
  logic [7:0]  e_attr;
  logic [31:0] e_rd;
  logic [2:0]  e_cnt;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_expect();
    logic [35:0] a = addr;
    e_hit = 0; e_idx = 0; e_attr = 0;
    for (int i = 3; i >= 0; i--) begin
      logic [7:0] mask = ~m_size[i][31:24];
      if (m_size[i][0] && a[35:32] == m_base[i][3:0] &&
          (a[31:24] & mask) == m_base[i][31:24]) begin
        e_hit = 1; e_idx = 2'(i);
      end
    end
    if (e_hit) e_attr = {3'b000, coh_en, 4'hF & ~(4'b1 << e_idx)};
    e_rd = reg_addr[2] ? m_size[reg_addr[4:3]] : m_base[reg_addr[4:3]];
    e_cnt = 0;
    for (int i = 0; i < 4; i++)
      if (m_size[i][0] && m_base[i][3:0] == 0) e_cnt++;
    if (reg_wr) begin
      if (reg_addr[2]) m_size[reg_addr[4:3]] = reg_wdata & 32'hFF00_001D;
      else             m_base[reg_addr[4:3]] = reg_wdata & 32'hFF00_000F;
    end
  endtask

  task automatic tick();
    model_expect();
    @(posedge clk); #1;
    chk("hit", 32'(hit), 32'(e_hit));
    chk("idx", 32'(cs_idx), 32'(e_idx));
    chk("attr", 32'(attr), 32'(e_attr));
    chk("rd_data", rd_data, e_rd);
    chk("count", 32'(cnt), 32'(e_cnt));
    chk("target_id", 32'(target_id), 32'd0);
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic look(logic [35:0] a);
    addr = a; tick();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_size[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    req = "R1";
    #1;
    chk("hit", 32'(hit), 0); chk("attr", 32'(attr), 0);
    chk("rd_data", rd_data, 0); chk("count", 32'(cnt), 0);
    look(36'h0_0000_0000);
    // R3: base programmed but rank disabled does not hit
    req = "R3";
    wr(5'h00, 32'h0000_0000);
    wr(5'h04, 32'h0F00_0000);
    look(36'h0_0100_0000);
    // R2: programming with stray bits; read back masked
    req = "R2";
    wr(5'h04, 32'h0FAB_CDED);        // en=1, csnum=3, sz=0x0F
    wr(5'h08, 32'h1012_3450);        // CS1 base 0x10000000
    wr(5'h0C, 32'h0000_0005);        // CS1 16MB, csnum 1
    wr(5'h10, 32'h0000_0001);        // CS2 base 0x1_00000000
    wr(5'h14, 32'h0000_0001);        // CS2 enabled
    for (int i = 0; i < 8; i++) begin reg_addr = 5'(i * 4); tick(); end
    // R4: hits and misses on window edges
    req = "R4";
    look(36'h0_0000_0000); look(36'h0_0FFF_FFFF);
    look(36'h0_1000_0000); look(36'h0_10FF_FFFF);
    look(36'h0_1100_0000); look(36'h0_8000_0000);
    // R8: upper address bits
    req = "R8";
    look(36'h1_0000_0000); look(36'h1_00FF_FFFF);
    look(36'h1_1000_0000); look(36'h2_0000_0000);
    // R9: count excludes CS2 (above 4 GB)
    req = "R9";
    tick();
    // R5: CS3 overlaps CS0; CS0 wins
    req = "R5";
    wr(5'h18, 32'h0000_0000);
    wr(5'h1C, 32'hFF00_0001);
    look(36'h0_0500_0000); look(36'h0_F000_0000);
    // R6: coherency flag merges into attribute
    req = "R6";
    coh_en = 1;
    look(36'h0_1000_0000); look(36'h0_F000_0000); look(36'h1_0000_0000);
    coh_en = 0;
    look(36'h0_1000_0000);
    // R7: misses return zero even with coherency on
    req = "R7";
    coh_en = 1;
    look(36'h3_0000_0000);
    coh_en = 0;
    // R10: write and lookup on the same edge see the old contents
    req = "R10";
    addr = 36'h0_0000_0000;
    wr(5'h04, 32'h0F00_0000);        // disable CS0, lookup still old
    look(36'h0_0000_0000);           // now CS3 wins
    wr(5'h1C, 32'h0000_0000);
    look(36'h0_0000_0000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule